// File: doc/BRIEF.md
# Quantized BVH Child Box Decoder

This block expands a compressed bounding-volume-hierarchy node into the full boxes of its two children. The node stores each child corner as a 5-bit index into a grid laid over the parent box. The grid pitch on each axis is a power of two: the smallest power of two that covers the parent edge, divided by 32. Because the pitch is a power of two, each child corner is the parent low coordinate plus a shifted index. The block needs no multiplier and no divider.

The caller gives a 12-byte node record and the parent box as unsigned fixed-point coordinates, one per axis. One cycle later the block returns the six corners of each child, the two 16-bit relative links held in the record, and three error flags. The flags mark a parent edge that is flat or reversed, a decoded corner that lies past the parent's high face, and a child whose high index is below its low index. The transfer uses a valid/ready handshake with one output register.

Top module: `bvh_child_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Node record layout. Index pair p = child*3 + axis (axis 0 = x, 1 = y, 2 = z) sits at bits [10p+4:10p] (low index) and [10p+9:10p+5] (high index). `child_link` is bits [75:60], `parent_link` is bits [91:76], and bits [95:92] are ignored. Both links appear on the outputs unchanged.
- R3: The grid pitch on an axis is 2^s, with s = max(ceil(log2(P1 - P0)) - 5, 0). When P1 <= P0, s = 0.
- R4: The child low corner on each axis equals P0 + (I0 << s), truncated to the coordinate width. Both children are decoded in the same transfer.
- R5: The child high corner on each axis equals P0 + ((I1 + 1) << s), truncated to the coordinate width.
- R6: `err_out_of_box` is 1 exactly when some decoded corner of either child, taken before truncation, is greater than that axis's P1.
- R7: `err_zero_edge` is 1 exactly when P1 <= P0 on some axis.
- R8: `err_inverted` is 1 exactly when I1 < I0 on some axis of either child.
- R9: An accepted input (`in_valid` and `in_ready` both high at a clock edge) appears on the outputs with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, the outputs stay unchanged and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Node record and parent box are present |
| in_ready | output | 1 | Block can take a new node this cycle |
| node_rec | input | 96 | Compressed node record |
| parent_lo | input | 48 | Parent low corner; axis a at [16a+15:16a] |
| parent_hi | input | 48 | Parent high corner; axis a at [16a+15:16a] |
| out_valid | output | 1 | Decoded result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| child_lo | output | 96 | Child low corners; child c, axis a at [16(3c+a)+15:16(3c+a)] |
| child_hi | output | 96 | Child high corners, same packing as child_lo |
| child_link | output | 16 | Relative link to the children, taken from the record |
| parent_link | output | 16 | Relative link to the parent, taken from the record |
| err_zero_edge | output | 1 | Some parent edge is flat or reversed |
| err_out_of_box | output | 1 | Some decoded corner lies past the parent high face |
| err_inverted | output | 1 | Some child high index is below its low index |

## Verification
The bound checker watches the handshake on every cycle: an accepted node must produce a valid result, and a stalled result must hold still with the input closed. On every valid result with no out-of-box flag, it also checks that each child low corner is at or above the captured parent low corner and that each high corner is at or below the parent high corner. When the inverted flag is also clear, it checks that each low corner is strictly below its high corner. The exact corner values, the power-of-two rounding of the pitch at and around each power-of-two edge length, the exact setting of each flag, and the field positions in the record are shown only by the bench. It sweeps edge lengths, runs every pair of low and high indices on one axis, and forces flat and reversed parent edges.

// File: rtl/bvh_dec_pkg.sv
package bvh_dec_pkg;
  localparam int AXES     = 3;
  localparam int CHILDREN = 2;

  typedef struct packed {
    logic zero_edge;
    logic out_of_box;
    logic inverted;
  } dec_err_t;
endpackage

// File: rtl/bvh_axis_scale.sv
// Per-axis grid pitch: log2 of the power of two covering the parent edge,
// reduced by the index width and clamped at zero.
module bvh_axis_scale #(
  parameter int COORD_W = 16,
  parameter int IDX_W   = 5,
  parameter int SH_W    = 5
) (
  input  logic [COORD_W-1:0] p_lo,
  input  logic [COORD_W-1:0] p_hi,
  output logic [SH_W-1:0]    shamt,
  output logic               degenerate
);
  // Ceiling log2 from a leading-one position plus an exact power-of-two test.
  function automatic logic [SH_W-1:0] ceil_log2(input logic [COORD_W-1:0] v);
    logic [SH_W-1:0] msb;
    logic            pow2;
    msb = '0;
    for (int i = 0; i < COORD_W; i++) begin
      if (v[i]) msb = SH_W'(i);
    end
    pow2 = ((v & (v - COORD_W'(1))) == '0);
    return pow2 ? msb : msb + SH_W'(1);
  endfunction

  logic [COORD_W-1:0] edge_len;
  logic [SH_W-1:0]    align_log;

  assign degenerate = (p_hi <= p_lo);
  assign edge_len   = degenerate ? '0 : (p_hi - p_lo);
  assign align_log  = ceil_log2(edge_len);
  assign shamt      = (align_log > SH_W'(IDX_W)) ? (align_log - SH_W'(IDX_W)) : '0;
endmodule

// File: rtl/bvh_corner_decode.sv
// One child on one axis: both corners by shift and add, plus range flags.
module bvh_corner_decode #(
  parameter int COORD_W = 16,
  parameter int IDX_W   = 5,
  parameter int SH_W    = 5
) (
  input  logic [COORD_W-1:0] p_lo,
  input  logic [COORD_W-1:0] p_hi,
  input  logic [IDX_W-1:0]   i_lo,
  input  logic [IDX_W-1:0]   i_hi,
  input  logic [SH_W-1:0]    shamt,
  output logic [COORD_W-1:0] c_lo,
  output logic [COORD_W-1:0] c_hi,
  output logic               beyond,
  output logic               inverted
);
  // Two guard bits: the shifted step reaches at most 2^COORD_W, plus the base.
  localparam int WIDE = COORD_W + 2;

  function automatic logic [WIDE-1:0] place(input logic [COORD_W-1:0] base,
                                            input logic [IDX_W:0]     steps,
                                            input logic [SH_W-1:0]    sh);
    return {2'b00, base} + (WIDE'(steps) << sh);
  endfunction

  logic [IDX_W:0]  hi_steps;
  logic [WIDE-1:0] lo_full;
  logic [WIDE-1:0] hi_full;

  assign hi_steps = {1'b0, i_hi} + {{IDX_W{1'b0}}, 1'b1};
  assign lo_full  = place(p_lo, {1'b0, i_lo}, shamt);
  assign hi_full  = place(p_lo, hi_steps, shamt);

  assign c_lo     = lo_full[COORD_W-1:0];
  assign c_hi     = hi_full[COORD_W-1:0];
  assign beyond   = (lo_full > {2'b00, p_hi}) || (hi_full > {2'b00, p_hi});
  assign inverted = (i_hi < i_lo);
endmodule

// File: rtl/bvh_node_unpack.sv
// Splits the node record into index pairs and the two relative links.
module bvh_node_unpack #(
  parameter int IDX_W  = 5,
  parameter int PTR_W  = 16,
  parameter int PAIRS  = 6,
  parameter int NODE_W = 96
) (
  input  logic [NODE_W-1:0]      node,
  output logic [PAIRS*IDX_W-1:0] idx_lo,
  output logic [PAIRS*IDX_W-1:0] idx_hi,
  output logic [PTR_W-1:0]       child_link,
  output logic [PTR_W-1:0]       parent_link
);
  localparam int LINK_BASE = PAIRS * 2 * IDX_W;
  localparam int USED_W    = LINK_BASE + 2 * PTR_W;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign idx_lo[p*IDX_W +: IDX_W] = node[p*2*IDX_W +: IDX_W];
    assign idx_hi[p*IDX_W +: IDX_W] = node[p*2*IDX_W + IDX_W +: IDX_W];
  end

  assign child_link  = node[LINK_BASE +: PTR_W];
  assign parent_link = node[LINK_BASE + PTR_W +: PTR_W];

  if (NODE_W > USED_W) begin : g_rsvd
    logic unused_rsvd;
    assign unused_rsvd = ^node[NODE_W-1:USED_W];
  end
endmodule

// File: rtl/bvh_child_decoder.sv
module bvh_child_decoder
  import bvh_dec_pkg::*;
#(
  parameter int COORD_W    = 16,
  parameter int IDX_W      = 5,
  parameter int PTR_W      = 16,
  parameter int NODE_BYTES = 12
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [NODE_BYTES*8-1:0]           node_rec,
  input  logic [AXES*COORD_W-1:0]           parent_lo,
  input  logic [AXES*COORD_W-1:0]           parent_hi,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [CHILDREN*AXES*COORD_W-1:0]  child_lo,
  output logic [CHILDREN*AXES*COORD_W-1:0]  child_hi,
  output logic [PTR_W-1:0]                  child_link,
  output logic [PTR_W-1:0]                  parent_link,
  output logic                              err_zero_edge,
  output logic                              err_out_of_box,
  output logic                              err_inverted
);
  localparam int PAIRS  = CHILDREN * AXES;
  localparam int NODE_W = NODE_BYTES * 8;
  localparam int SH_W   = $clog2(COORD_W + 1);
  localparam int BOX_W  = PAIRS * COORD_W;

  // Named internal events, used by the bound checker.
  logic accept;

  logic [PAIRS*IDX_W-1:0] idx_lo;
  logic [PAIRS*IDX_W-1:0] idx_hi;
  logic [PTR_W-1:0]       d_child_link;
  logic [PTR_W-1:0]       d_parent_link;
  logic [AXES*SH_W-1:0]   axis_shamt;
  logic [AXES-1:0]        axis_degen;
  logic [PAIRS-1:0]       pair_beyond;
  logic [PAIRS-1:0]       pair_inv;
  logic [BOX_W-1:0]       d_lo;
  logic [BOX_W-1:0]       d_hi;
  dec_err_t               d_err;

  bvh_node_unpack #(
    .IDX_W (IDX_W),
    .PTR_W (PTR_W),
    .PAIRS (PAIRS),
    .NODE_W(NODE_W)
  ) u_unpack (
    .node       (node_rec),
    .idx_lo     (idx_lo),
    .idx_hi     (idx_hi),
    .child_link (d_child_link),
    .parent_link(d_parent_link)
  );

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    bvh_axis_scale #(
      .COORD_W(COORD_W),
      .IDX_W  (IDX_W),
      .SH_W   (SH_W)
    ) u_scale (
      .p_lo      (parent_lo[a*COORD_W +: COORD_W]),
      .p_hi      (parent_hi[a*COORD_W +: COORD_W]),
      .shamt     (axis_shamt[a*SH_W +: SH_W]),
      .degenerate(axis_degen[a])
    );
  end

  for (genvar c = 0; c < CHILDREN; c++) begin : g_child
    for (genvar a = 0; a < AXES; a++) begin : g_axis
      localparam int P = c * AXES + a;
      bvh_corner_decode #(
        .COORD_W(COORD_W),
        .IDX_W  (IDX_W),
        .SH_W   (SH_W)
      ) u_corner (
        .p_lo    (parent_lo[a*COORD_W +: COORD_W]),
        .p_hi    (parent_hi[a*COORD_W +: COORD_W]),
        .i_lo    (idx_lo[P*IDX_W +: IDX_W]),
        .i_hi    (idx_hi[P*IDX_W +: IDX_W]),
        .shamt   (axis_shamt[a*SH_W +: SH_W]),
        .c_lo    (d_lo[P*COORD_W +: COORD_W]),
        .c_hi    (d_hi[P*COORD_W +: COORD_W]),
        .beyond  (pair_beyond[P]),
        .inverted(pair_inv[P])
      );
    end
  end

  always_comb begin
    d_err.zero_edge  = |axis_degen;
    d_err.out_of_box = |pair_beyond;
    d_err.inverted   = |pair_inv;
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  dec_err_t err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      child_lo    <= '0;
      child_hi    <= '0;
      child_link  <= '0;
      parent_link <= '0;
      err_q       <= '0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      child_lo    <= d_lo;
      child_hi    <= d_hi;
      child_link  <= d_child_link;
      parent_link <= d_parent_link;
      err_q       <= d_err;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  assign err_zero_edge  = err_q.zero_edge;
  assign err_out_of_box = err_q.out_of_box;
  assign err_inverted   = err_q.inverted;
endmodule

// File: rtl/bvh_child_decoder_chk.sv
module bvh_child_decoder_chk #(
  parameter int COORD_W = 16,
  parameter int AXES    = 3,
  parameter int PAIRS   = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     accept,
  input logic                     in_ready,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [AXES*COORD_W-1:0]  parent_lo,
  input logic [AXES*COORD_W-1:0]  parent_hi,
  input logic [PAIRS*COORD_W-1:0] child_lo,
  input logic [PAIRS*COORD_W-1:0] child_hi,
  input logic                     err_zero_edge,
  input logic                     err_out_of_box,
  input logic                     err_inverted
);
  logic [AXES*COORD_W-1:0] cap_lo;
  logic [AXES*COORD_W-1:0] cap_hi;
  logic lo_in_box, hi_in_box, lo_below_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_lo <= '0;
      cap_hi <= '0;
    end else if (accept) begin
      cap_lo <= parent_lo;
      cap_hi <= parent_hi;
    end
  end

  always_comb begin
    lo_in_box   = 1'b1;
    hi_in_box   = 1'b1;
    lo_below_hi = 1'b1;
    for (int p = 0; p < PAIRS; p++) begin
      if (child_lo[p*COORD_W +: COORD_W] < cap_lo[(p % AXES)*COORD_W +: COORD_W]) lo_in_box = 1'b0;
      if (child_hi[p*COORD_W +: COORD_W] > cap_hi[(p % AXES)*COORD_W +: COORD_W]) hi_in_box = 1'b0;
      if (child_lo[p*COORD_W +: COORD_W] >= child_hi[p*COORD_W +: COORD_W]) lo_below_hi = 1'b0;
    end
  end

  a_r9_accept_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(child_lo) && $stable(child_hi)
      && $stable(err_zero_edge) && $stable(err_out_of_box) && $stable(err_inverted)));

  a_r9_stall_closes_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r4_low_inside_parent: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !err_out_of_box) |-> lo_in_box);

  a_r6_high_inside_parent: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !err_out_of_box) |-> hi_in_box);

  a_r8_corners_ordered: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !err_out_of_box && !err_inverted) |-> lo_below_hi);
endmodule

bind bvh_child_decoder bvh_child_decoder_chk #(
  .COORD_W(COORD_W),
  .AXES   (AXES),
  .PAIRS  (PAIRS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .accept        (accept),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .parent_lo     (parent_lo),
  .parent_hi     (parent_hi),
  .child_lo      (child_lo),
  .child_hi      (child_hi),
  .err_zero_edge (err_zero_edge),
  .err_out_of_box(err_out_of_box),
  .err_inverted  (err_inverted)
);

// File: tb/bvh_child_decoder_bench.sv
module bvh_child_decoder_bench;
  localparam int CW = 16;
  localparam int PW = 16;
  localparam int NW = 96;
  localparam int AX = 3;
  localparam int CH = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [NW-1:0]     node_rec = '0;
  logic [AX*CW-1:0]  parent_lo = '0;
  logic [AX*CW-1:0]  parent_hi = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [CH*AX*CW-1:0] child_lo;
  logic [CH*AX*CW-1:0] child_hi;
  logic [PW-1:0]     child_link;
  logic [PW-1:0]     parent_link;
  logic              err_zero_edge;
  logic              err_out_of_box;
  logic              err_inverted;

  bvh_child_decoder u_bvh_child_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .node_rec(node_rec), .parent_lo(parent_lo), .parent_hi(parent_hi),
    .out_valid(out_valid), .out_ready(out_ready),
    .child_lo(child_lo), .child_hi(child_hi),
    .child_link(child_link), .parent_link(parent_link),
    .err_zero_edge(err_zero_edge), .err_out_of_box(err_out_of_box),
    .err_inverted(err_inverted)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int ilo[CH][AX];
  int ihi[CH][AX];
  int plo[AX];
  int phi[AX];
  int cptr, pptr;
  int edges[128];
  int n_edges = 0;

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pitch_log(int lo, int hi);
    int p = 0;
    if (hi <= lo) return 0;
    while ((1 << p) < (hi - lo)) p++;
    return (p > 5) ? p - 5 : 0;
  endfunction

  function automatic logic [NW-1:0] pack_node();
    logic [NW-1:0] n = '0;
    for (int c = 0; c < CH; c++)
      for (int a = 0; a < AX; a++) begin
        n[(c*AX+a)*10 +: 5]     = 5'(ilo[c][a]);
        n[(c*AX+a)*10 + 5 +: 5] = 5'(ihi[c][a]);
      end
    n[60 +: 16] = 16'(cptr);
    n[76 +: 16] = 16'(pptr);
    n[92 +: 4]  = 4'hb;
    return n;
  endfunction

  task automatic load_inputs();
    node_rec = pack_node();
    for (int a = 0; a < AX; a++) begin
      parent_lo[a*CW +: CW] = 16'(plo[a]);
      parent_hi[a*CW +: CW] = 16'(phi[a]);
    end
  endtask

  task automatic send();
    @(negedge clk);
    load_inputs();
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Compare the current outputs with the arithmetic model of R2..R9.
  task automatic verify();
    bit oob = 0, inv = 0, zer = 0;
    check("R9 out_valid", out_valid, 1);
    for (int a = 0; a < AX; a++) begin
      int s = pitch_log(plo[a], phi[a]);
      if (phi[a] <= plo[a]) zer = 1;
      for (int c = 0; c < CH; c++) begin
        longint elo = longint'(plo[a]) + (longint'(ilo[c][a]) << s);
        longint ehi = longint'(plo[a]) + (longint'(ihi[c][a] + 1) << s);
        if (elo > phi[a] || ehi > phi[a]) oob = 1;
        if (ihi[c][a] < ilo[c][a]) inv = 1;
        check("R4 low corner", child_lo[(c*AX+a)*CW +: CW], elo & 16'hffff);
        check("R5 high corner", child_hi[(c*AX+a)*CW +: CW], ehi & 16'hffff);
      end
    end
    check("R6 out of box", err_out_of_box, oob);
    check("R7 zero edge", err_zero_edge, zer);
    check("R8 inverted", err_inverted, inv);
    check("R2 child link", child_link, cptr & 16'hffff);
    check("R2 parent link", parent_link, pptr & 16'hffff);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // Edge lengths: every small edge plus each power of two and its neighbours.
    for (int e = 1; e <= 80; e++) begin edges[n_edges] = e; n_edges++; end
    for (int k = 7; k <= 15; k++) begin
      edges[n_edges] = (1 << k) - 1; n_edges++;
      edges[n_edges] = (1 << k);     n_edges++;
      edges[n_edges] = (1 << k) + 1; n_edges++;
    end
    edges[n_edges] = 65534; n_edges++;
    edges[n_edges] = 65535; n_edges++;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 out_valid in reset", out_valid, 0);
    check("R1 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", out_valid, 0);
    check("R1 in_ready after reset", in_ready, 1);

    // R3..R8: edge sweep with varied indices; child 1 probes the pitch.
    for (int t = 0; t < n_edges; t++) begin
      for (int a = 0; a < AX; a++) begin
        int e = edges[(t + a*13) % n_edges];
        plo[a] = (t*977 + a*4099) % (65536 - e);
        phi[a] = plo[a] + e;
        ilo[0][a] = (t*3 + a*5) % 32;
        ihi[0][a] = ilo[0][a] + ((t + a) % (32 - ilo[0][a]));
        ilo[1][a] = 1;
        ihi[1][a] = 1;
      end
      cptr = (t * 32'h1357) & 16'hffff;
      pptr = (t * 32'h2468 + 7) & 16'hffff;
      send();
      verify();
      for (int a = 0; a < AX; a++)
        check("R3 pitch", (child_lo[(AX+a)*CW +: CW] - 16'(plo[a])) & 16'hffff,
              (1 << pitch_log(plo[a], phi[a])) & 16'hffff);
    end

    // R4..R8: every index pair on x of child 0, edge 40 (pitch 2).
    for (int lo = 0; lo < 32; lo++)
      for (int hi = 0; hi < 32; hi++) begin
        for (int a = 0; a < AX; a++) begin
          plo[a] = 1000; phi[a] = 1040;
          for (int c = 0; c < CH; c++) begin ilo[c][a] = 0; ihi[c][a] = 0; end
        end
        ilo[0][0] = lo; ihi[0][0] = hi;
        cptr = lo * 32 + hi; pptr = 16'hffff - cptr;
        send();
        verify();
      end

    // R7: flat and reversed parent edge on y.
    for (int k = 0; k < 2; k++) begin
      for (int a = 0; a < AX; a++) begin
        plo[a] = 500; phi[a] = 600;
        for (int c = 0; c < CH; c++) begin ilo[c][a] = 2; ihi[c][a] = 4; end
      end
      phi[1] = (k == 0) ? 500 : 400;
      cptr = 11; pptr = 22;
      send();
      verify();
    end

    // R9: backpressure holds result A and blocks B until released.
    for (int a = 0; a < AX; a++) begin
      plo[a] = 10; phi[a] = 50;
      for (int c = 0; c < CH; c++) begin ilo[c][a] = 1; ihi[c][a] = 3; end
    end
    cptr = 16'h0a0a; pptr = 16'h0b0b;
    @(negedge clk);
    out_ready = 1'b0;
    send();
    verify();
    check("R9 in_ready while stalled", in_ready, 0);
    cptr = 16'h0c0c; pptr = 16'h0d0d;
    ilo[0][0] = 5; ihi[0][0] = 6;
    load_inputs();
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9 held link during stall", child_link, 16'h0a0a);
    check("R9 still valid during stall", out_valid, 1);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    verify();
    @(posedge clk);
    @(negedge clk);
    check("R9 drains after take", out_valid, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule